// File: doc/BRIEF.md
# Multiplexed-Bus Transfer Cycle Sequencer

This block produces the external bus cycles of an 8-bit processor whose low address byte and data byte share one set of lines. It handles four transfers: port output, port input, direct store and direct load. A start pulse begins one transfer. The sequencer first fetches the opcode at the program counter. It then fetches one operand byte (a port number) or two operand bytes (a 16-bit memory address), and finally runs the data cycle. Each T-state lasts one clock.

The block drives several outputs: the upper address byte, the shared low byte, an output enable for the shared lines, the address latch pulse, the I/O-versus-memory select, and the read and write controls. It decodes these into four active-low strobes: memory read, memory write, I/O read and I/O write. Bytes read from the bus are captured at the end of T3. The accumulator is loaded by input and load transfers and is driven out by output and store transfers. Any opcode other than the four supported ones ends the transfer after the fetch and raises an error flag.

Top module: `io_cycle_seq`

## Requirements
- R1: After reset the following hold: all four strobes, `rd_n` and `wr_n` are high; `ale`, `io_m`, `ad_oe`, `done` and `err` are low; `acc` is 00h; and `{addr_hi,ad_out}` shows the reset program counter (default 2000h).
- R2: A `start` sampled high while idle makes the next clock T1 of the opcode fetch. In that T1, `ale` and `ad_oe` are high, `io_m` is low and `{addr_hi,ad_out}` equals the program counter.
- R3: Every memory read cycle holds `rd_n` and `memr_n` low with `ad_oe` low in T2 and T3, and captures `ad_in` at the end of T3. The opcode fetch adds a T4 with `rd_n` high and `ale` low. The program counter advances by one per byte fetched, so each operand cycle addresses the byte after the previous one.
- R4: Opcode D3h (port output) runs 10 clocks. In T1 of its third cycle the port number appears on both `addr_hi` and `ad_out`, and `io_m` is high for exactly that cycle's three clocks. In T2 and T3, `wr_n` and `iow_n` are low, `ad_oe` is high and `ad_out` carries the accumulator unchanged.
- R5: Opcode DBh (port input) runs 10 clocks. Its third cycle addresses the port on both halves with `io_m` high. It holds `rd_n` and `ior_n` low and `ad_oe` low in T2 and T3, and loads the bus byte into `acc` at the end of T3.
- R6: Opcode 32h (direct store) runs 13 clocks. Bytes two and three are the low and high address. The fourth cycle puts `{byte3,byte2}` on the bus in T1 and holds `memw_n` low in T2 and T3 with the accumulator on `ad_out`. `io_m` stays low throughout.
- R7: Opcode 3Ah (direct load) uses the same 13-clock addressing as R6. It holds `memr_n` low in T2 and T3 of the fourth cycle and loads that byte into `acc`.
- R8: `done` is high for exactly one clock per transfer, in its final T-state.
- R9: At most one of the four strobes is low in any clock. `ior_n` and `iow_n` go low only while `io_m` is high; `memr_n` and `memw_n` go low only while `io_m` is low.
- R10: Any other opcode still takes the full 4-clock fetch, with `done` high in T4. The block then returns to idle with no strobe and no `ale`. `err` is high from the clock after that T4 until the next accepted `start`, and the next transfer fetches at the following address.
- R11: A `start` that arrives during a transfer is ignored: the transfer keeps its length and no new fetch follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one transfer when idle |
| ad_in | input | 8 | Byte read from the shared lines |
| addr_hi | output | 8 | Upper address byte |
| ad_out | output | 8 | Low address in T1, write data in T2/T3 |
| ad_oe | output | 1 | Block drives the shared lines |
| ale | output | 1 | Address latch pulse, high in T1 |
| io_m | output | 1 | High for an I/O cycle, low for memory |
| rd_n | output | 1 | Read control, active low |
| wr_n | output | 1 | Write control, active low |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| ior_n | output | 1 | I/O read strobe, active low |
| iow_n | output | 1 | I/O write strobe, active low |
| done | output | 1 | Final T-state of a transfer |
| err | output | 1 | Last fetched opcode was not supported |
| acc | output | 8 | Accumulator |

## Verification
All bus outputs are decoded from registered state, so they change one clock after the edge that moves the sequencer. Counting from the first falling edge after the accepting rising edge as index 0, the operand cycles begin at index 4 and at index 7. Port transfers finish at index 9, direct transfers put their data cycle at 10–12, and a rejected opcode ends at index 3 with `err` visible at index 4. The bench records sixteen falling-edge samples per transfer and checks each expected value at exactly those indices. Captured bytes (`acc`, the model memory, the port latch) are checked only after the transfer has ended.

// File: rtl/io_seq_pkg.sv
package io_seq_pkg;

    localparam int DW = 8;
    localparam int AW = 2 * DW;
    localparam int TW = 2;

    localparam logic [DW-1:0] OPC_PORT_OUT = 8'hD3;
    localparam logic [DW-1:0] OPC_PORT_IN  = 8'hDB;
    localparam logic [DW-1:0] OPC_STORE    = 8'h32;
    localparam logic [DW-1:0] OPC_LOAD     = 8'h3A;

    localparam logic [TW-1:0] T_SAMPLE     = TW'(2);
    localparam logic [TW-1:0] T_END_FETCH  = TW'(3);
    localparam logic [TW-1:0] T_END_RW     = TW'(2);

    typedef enum logic [1:0] {
        XF_PORT_OUT,
        XF_PORT_IN,
        XF_STORE,
        XF_LOAD
    } xfer_e;

    typedef enum logic [2:0] {
        MC_IDLE,
        MC_FETCH,
        MC_ARG1,
        MC_ARG2,
        MC_XFER
    } mcyc_e;

    typedef struct packed {
        logic  valid;
        xfer_e kind;
    } op_info_t;

    typedef struct packed {
        logic ale;
        logic io_m;
        logic rd_n;
        logic wr_n;
        logic ad_oe;
    } bus_ctl_t;

    function automatic op_info_t decode_op(input logic [DW-1:0] op);
        op_info_t r;
        r.valid = 1'b1;
        r.kind  = XF_PORT_OUT;
        case (op)
            OPC_PORT_OUT: r.kind = XF_PORT_OUT;
            OPC_PORT_IN:  r.kind = XF_PORT_IN;
            OPC_STORE:    r.kind = XF_STORE;
            OPC_LOAD:     r.kind = XF_LOAD;
            default:      r.valid = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic is_port(input xfer_e k);
        return (k == XF_PORT_OUT) || (k == XF_PORT_IN);
    endfunction

    function automatic logic is_write(input xfer_e k);
        return (k == XF_PORT_OUT) || (k == XF_STORE);
    endfunction

endpackage

// File: rtl/io_seq_fsm.sv
module io_seq_fsm
    import io_seq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  op_info_t      info,
    output mcyc_e         mc,
    output logic [TW-1:0] tst,
    output logic          accept,
    output logic          done
);

    mcyc_e         mc_n;
    logic [TW-1:0] t_n;
    logic          at_end;

    assign accept = start && (mc == MC_IDLE);
    assign at_end = (mc == MC_FETCH) ? (tst == T_END_FETCH) : (tst == T_END_RW);
    assign done   = (mc != MC_IDLE) && at_end &&
                    ((mc == MC_XFER) || ((mc == MC_FETCH) && !info.valid));

    always_comb begin
        mc_n = mc;
        t_n  = tst + TW'(1);
        if (mc == MC_IDLE) begin
            t_n = '0;
            if (start) mc_n = MC_FETCH;
        end else if (at_end) begin
            t_n = '0;
            case (mc)
                MC_FETCH: mc_n = info.valid ? MC_ARG1 : MC_IDLE;
                MC_ARG1:  mc_n = is_port(info.kind) ? MC_XFER : MC_ARG2;
                MC_ARG2:  mc_n = MC_XFER;
                default:  mc_n = MC_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mc  <= MC_IDLE;
            tst <= '0;
        end else begin
            mc  <= mc_n;
            tst <= t_n;
        end
    end

    AST_START_FETCH: assert property (@(posedge clk) disable iff (rst)
        accept |=> (mc == MC_FETCH) && (tst == '0)); // R2

    AST_FETCH_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        ((mc == MC_FETCH) && (tst == '0)) |-> ($past(mc) == MC_IDLE)); // R11

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

endmodule

// File: rtl/io_seq_regs.sv
module io_seq_regs
    import io_seq_pkg::*;
#(
    parameter logic [AW-1:0] RESET_PC = 16'h2000
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  mcyc_e         mc,
    input  logic [TW-1:0] tst,
    input  logic [DW-1:0] ad_in,
    output op_info_t      info,
    output logic [AW-1:0] pc,
    output logic [DW-1:0] arg1,
    output logic [DW-1:0] arg2,
    output logic [DW-1:0] acc,
    output logic          err
);

    logic [DW-1:0] opcode;
    logic          sample;

    assign info   = decode_op(opcode);
    assign sample = (tst == T_SAMPLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc     <= RESET_PC;
            opcode <= '0;
            arg1   <= '0;
            arg2   <= '0;
            acc    <= '0;
            err    <= 1'b0;
        end else begin
            if (accept) err <= 1'b0;
            case (mc)
                MC_FETCH: begin
                    if (sample) begin
                        opcode <= ad_in;
                        pc     <= pc + AW'(1);
                    end else if ((tst == T_END_FETCH) && !info.valid) begin
                        err <= 1'b1;
                    end
                end
                MC_ARG1: if (sample) begin
                    arg1 <= ad_in;
                    pc   <= pc + AW'(1);
                end
                MC_ARG2: if (sample) begin
                    arg2 <= ad_in;
                    pc   <= pc + AW'(1);
                end
                MC_XFER: if (sample && !is_write(info.kind)) begin
                    acc <= ad_in;
                end
                default: ;
            endcase
        end
    end

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (pc != $past(pc)) |-> (pc == $past(pc) + AW'(1))); // R3

    AST_ACC_FROM_XFER: assert property (@(posedge clk) disable iff (rst)
        (acc != $past(acc)) |-> ($past(mc) == MC_XFER)); // R7

    AST_ERR_AFTER_FETCH: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> ($past(mc) == MC_FETCH)); // R10

endmodule

// File: rtl/io_seq_bus.sv
module io_seq_bus
    import io_seq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  mcyc_e         mc,
    input  logic [TW-1:0] tst,
    input  xfer_e         kind,
    input  logic [AW-1:0] pc,
    input  logic [DW-1:0] arg1,
    input  logic [DW-1:0] arg2,
    input  logic [DW-1:0] acc,
    output logic [DW-1:0] addr_hi,
    output logic [DW-1:0] ad_out,
    output bus_ctl_t      ctl
);

    logic [AW-1:0] addr;
    logic          in_xfer;
    logic          write_cyc;

    assign in_xfer   = (mc == MC_XFER);
    assign write_cyc = in_xfer && is_write(kind);

    always_comb begin
        addr = pc;
        if (in_xfer) addr = is_port(kind) ? {arg1, arg1} : {arg2, arg1};
    end

    always_comb begin
        ctl      = '{ale: 1'b0, io_m: 1'b0, rd_n: 1'b1, wr_n: 1'b1, ad_oe: 1'b0};
        ad_out   = addr[DW-1:0];
        addr_hi  = addr[AW-1:DW];
        ctl.io_m = in_xfer && is_port(kind);
        if (mc != MC_IDLE) begin
            if (tst == '0) begin
                ctl.ale   = 1'b1;
                ctl.ad_oe = 1'b1;
            end else if (tst != T_END_FETCH) begin
                if (write_cyc) begin
                    ctl.wr_n  = 1'b0;
                    ctl.ad_oe = 1'b1;
                    ad_out    = acc;
                end else begin
                    ctl.rd_n  = 1'b0;
                end
            end
        end
    end

    AST_IOM_RISE_AT_T1: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl.io_m) |-> ctl.ale); // R4

    AST_IOM_FALL_AT_END: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl.io_m) |-> (ctl.ale || (mc == MC_IDLE))); // R4

    AST_WR_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        (!ctl.wr_n && $past(!ctl.wr_n)) |-> ($stable(ad_out) && ctl.ad_oe)); // R4

endmodule

// File: rtl/io_seq_strobe.sv
module io_seq_strobe (
    input  logic clk,
    input  logic rst,
    input  logic io_m,
    input  logic rd_n,
    input  logic wr_n,
    output logic memr_n,
    output logic memw_n,
    output logic ior_n,
    output logic iow_n
);

    assign memr_n = io_m  | rd_n;
    assign memw_n = io_m  | wr_n;
    assign ior_n  = !io_m | rd_n;
    assign iow_n  = !io_m | wr_n;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({!memr_n, !memw_n, !ior_n, !iow_n})); // R9

endmodule

// File: rtl/io_cycle_seq.sv
module io_cycle_seq
    import io_seq_pkg::*;
#(
    parameter logic [AW-1:0] RESET_PC = 16'h2000
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] addr_hi,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    output logic          ale,
    output logic          io_m,
    output logic          rd_n,
    output logic          wr_n,
    output logic          memr_n,
    output logic          memw_n,
    output logic          ior_n,
    output logic          iow_n,
    output logic          done,
    output logic          err,
    output logic [DW-1:0] acc
);

    mcyc_e         mc;
    logic [TW-1:0] tst;
    logic          accept;
    op_info_t      info;
    logic [AW-1:0] pc;
    logic [DW-1:0] arg1;
    logic [DW-1:0] arg2;
    bus_ctl_t      ctl;

    io_seq_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .info   (info),
        .mc     (mc),
        .tst    (tst),
        .accept (accept),
        .done   (done)
    );

    io_seq_regs #(.RESET_PC(RESET_PC)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .mc     (mc),
        .tst    (tst),
        .ad_in  (ad_in),
        .info   (info),
        .pc     (pc),
        .arg1   (arg1),
        .arg2   (arg2),
        .acc    (acc),
        .err    (err)
    );

    io_seq_bus u_bus (
        .clk     (clk),
        .rst     (rst),
        .mc      (mc),
        .tst     (tst),
        .kind    (info.kind),
        .pc      (pc),
        .arg1    (arg1),
        .arg2    (arg2),
        .acc     (acc),
        .addr_hi (addr_hi),
        .ad_out  (ad_out),
        .ctl     (ctl)
    );

    assign ale   = ctl.ale;
    assign io_m  = ctl.io_m;
    assign rd_n  = ctl.rd_n;
    assign wr_n  = ctl.wr_n;
    assign ad_oe = ctl.ad_oe;

    io_seq_strobe u_strobe (
        .clk    (clk),
        .rst    (rst),
        .io_m   (ctl.io_m),
        .rd_n   (ctl.rd_n),
        .wr_n   (ctl.wr_n),
        .memr_n (memr_n),
        .memw_n (memw_n),
        .ior_n  (ior_n),
        .iow_n  (iow_n)
    );

endmodule

// File: tb/tb_io_cycle_seq.sv
module tb_io_cycle_seq;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [7:0] ad_in;
    logic [7:0] addr_hi, ad_out, acc;
    logic ad_oe, ale, io_m, rd_n, wr_n, memr_n, memw_n, ior_n, iow_n, done, err;

    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    io_cycle_seq #(.RESET_PC(16'h2000)) dut (
        .clk(clk), .rst(rst), .start(start), .ad_in(ad_in),
        .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ale(ale),
        .io_m(io_m), .rd_n(rd_n), .wr_n(wr_n), .memr_n(memr_n),
        .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n), .done(done),
        .err(err), .acc(acc)
    );

    // bus model: 256-byte memory on the low address byte, port reads return port ^ 5Ah
    logic [7:0]  mem [256];
    logic [15:0] lat_addr;
    logic [7:0]  port_addr, port_data;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
            mem[8'h00] <= 8'hDB; mem[8'h01] <= 8'h84;
            mem[8'h02] <= 8'hD3; mem[8'h03] <= 8'hF5;
            mem[8'h04] <= 8'h32; mem[8'h05] <= 8'hF0; mem[8'h06] <= 8'h80;
            mem[8'h07] <= 8'h3A; mem[8'h08] <= 8'hF1; mem[8'h09] <= 8'h80;
            mem[8'h0A] <= 8'hD3; mem[8'h0B] <= 8'h10;
            mem[8'h0C] <= 8'h76;
            mem[8'h0D] <= 8'hDB; mem[8'h0E] <= 8'h01;
            mem[8'hF1] <= 8'h3C;
            lat_addr   <= 16'h0;
            port_addr  <= 8'h00;
            port_data  <= 8'h00;
        end else begin
            if (ale) lat_addr <= {addr_hi, ad_out};
            if (!wr_n) begin
                if (io_m) begin
                    port_addr <= lat_addr[7:0];
                    port_data <= ad_out;
                end else begin
                    mem[lat_addr[7:0]] <= ad_out;
                end
            end
        end
    end

    assign ad_in = rd_n ? 8'h00 : (io_m ? (lat_addr[7:0] ^ 8'h5A) : mem[lat_addr[7:0]]);

    typedef struct packed {
        logic ale, io_m, rd_n, wr_n, ad_oe, memr_n, memw_n, ior_n, iow_n, done, err;
        logic [7:0] hi, lo;
    } smp_t;

    smp_t tr [16];

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // start at a falling edge, then take 16 falling-edge samples (index 0 = fetch T1)
    task automatic run(input int poke);
        @(negedge clk);
        start = 1'b1;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            tr[k] = {ale, io_m, rd_n, wr_n, ad_oe, memr_n, memw_n, ior_n, iow_n,
                     done, err, addr_hi, ad_out};
            start = (k == poke);
        end
        start = 1'b0;
    endtask

    task automatic chk_read_cycle(input int b, input logic [15:0] a, input string rq);
        chk(rq, "ale in T1", 16'(tr[b].ale), 16'd1);
        chk(rq, "address in T1", {tr[b].hi, tr[b].lo}, a);
        chk(rq, "ad_oe in T1", 16'(tr[b].ad_oe), 16'd1);
        chk("R3", "memr_n in T2", 16'(tr[b+1].memr_n), 16'd0);
        chk("R3", "rd_n in T3", 16'(tr[b+2].rd_n), 16'd0);
        chk("R3", "ad_oe in T3", 16'(tr[b+2].ad_oe), 16'd0);
    endtask

    task automatic chk_common(input int last);
        int ndone = 0, nbad = 0;
        for (int k = 0; k < 16; k++) begin
            ndone += int'(tr[k].done);
            if ($countones({!tr[k].memr_n, !tr[k].memw_n, !tr[k].ior_n, !tr[k].iow_n}) > 1)
                nbad++;
            if ((!tr[k].ior_n || !tr[k].iow_n) && !tr[k].io_m) nbad++;
        end
        chk("R8", "done count", 16'(ndone), 16'd1);
        chk("R8", "done in final T-state", 16'(tr[last].done), 16'd1);
        chk("R9", "strobe violations", 16'(nbad), 16'd0);
        chk("R3", "fetch T4 rd_n", 16'(tr[3].rd_n), 16'd1);
        chk("R3", "fetch T4 ale", 16'(tr[3].ale), 16'd0);
    endtask

    task automatic port_xfer(input logic [15:0] pc0, input logic is_out,
                             input logic [7:0] port, input logic [7:0] val, input int poke);
        int nio = 0, nale = 0, nidle = 0;
        string rq;
        rq = is_out ? "R4" : "R5";
        run(poke);
        chk_read_cycle(0, pc0, "R2");
        chk_read_cycle(4, pc0 + 16'd1, "R3");
        chk_common(9);
        chk(rq, "port on both halves", {tr[7].hi, tr[7].lo}, {port, port});
        for (int k = 0; k < 16; k++) begin
            nio  += int'(tr[k].io_m);
            nale += int'(tr[k].ale);
            if (k > 9 && (tr[k].ale || tr[k].done)) nidle++;
        end
        chk(rq, "io_m clocks", 16'(nio), 16'd3);
        chk(rq, "io_m in third cycle T1", 16'(tr[7].io_m), 16'd1);
        if (is_out) begin
            chk("R4", "iow_n T2", 16'(tr[8].iow_n), 16'd0);
            chk("R4", "iow_n T3", 16'(tr[9].iow_n), 16'd0);
            chk("R4", "ad_oe T3", 16'(tr[9].ad_oe), 16'd1);
            chk("R4", "data T2", 16'(tr[8].lo), 16'(val));
            chk("R4", "data T3", 16'(tr[9].lo), 16'(val));
            chk("R4", "port written", {port_addr, port_data}, {port, val});
        end else begin
            chk("R5", "ior_n T2", 16'(tr[8].ior_n), 16'd0);
            chk("R5", "ior_n T3", 16'(tr[9].ior_n), 16'd0);
            chk("R5", "ad_oe T3", 16'(tr[9].ad_oe), 16'd0);
            chk("R5", "acc loaded", 16'(acc), 16'(val));
        end
        if (poke >= 0) begin
            chk("R11", "ale pulses", 16'(nale), 16'd3);
            chk("R11", "activity after done", 16'(nidle), 16'd0);
        end
    endtask

    task automatic dir_xfer(input logic [15:0] pc0, input logic is_store,
                            input logic [15:0] a, input logic [7:0] val);
        int nio = 0;
        string rq;
        rq = is_store ? "R6" : "R7";
        run(-1);
        chk_read_cycle(0, pc0, "R2");
        chk_read_cycle(4, pc0 + 16'd1, "R3");
        chk_read_cycle(7, pc0 + 16'd2, "R3");
        chk_common(12);
        chk(rq, "ale data T1", 16'(tr[10].ale), 16'd1);
        chk(rq, "full address", {tr[10].hi, tr[10].lo}, a);
        for (int k = 0; k < 16; k++) nio += int'(tr[k].io_m);
        chk(rq, "io_m high clocks", 16'(nio), 16'd0);
        if (is_store) begin
            chk("R6", "memw_n T2", 16'(tr[11].memw_n), 16'd0);
            chk("R6", "memw_n T3", 16'(tr[12].memw_n), 16'd0);
            chk("R6", "data T3", 16'(tr[12].lo), 16'(val));
            chk("R6", "memory written", 16'(mem[a[7:0]]), 16'(val));
        end else begin
            chk("R7", "memr_n T2", 16'(tr[11].memr_n), 16'd0);
            chk("R7", "memr_n T3", 16'(tr[12].memr_n), 16'd0);
            chk("R7", "acc loaded", 16'(acc), 16'(val));
        end
    endtask

    task automatic bad_op(input logic [15:0] pc0);
        int nact = 0;
        run(-1);
        chk_read_cycle(0, pc0, "R2");
        chk_common(3);
        chk("R10", "err before", 16'(tr[3].err), 16'd0);
        chk("R10", "err raised", 16'(tr[4].err), 16'd1);
        for (int k = 4; k < 16; k++)
            if (tr[k].ale || !tr[k].memr_n || !tr[k].memw_n || !tr[k].ior_n || !tr[k].iow_n)
                nact++;
        chk("R10", "bus activity after reject", 16'(nact), 16'd0);
        chk("R10", "err held", 16'(err), 16'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "strobes", {12'd0, memr_n, memw_n, ior_n, iow_n}, 16'h000F);
        chk("R1", "rd_n/wr_n", {14'd0, rd_n, wr_n}, 16'h0003);
        chk("R1", "ale/io_m/ad_oe/done/err", {11'd0, ale, io_m, ad_oe, done, err}, 16'h0000);
        chk("R1", "acc", 16'(acc), 16'h0000);
        chk("R1", "address", {addr_hi, ad_out}, 16'h2000);

        port_xfer(16'h2000, 1'b0, 8'h84, 8'hDE, -1);
        port_xfer(16'h2002, 1'b1, 8'hF5, 8'hDE, -1);
        dir_xfer (16'h2004, 1'b1, 16'h80F0, 8'hDE);
        dir_xfer (16'h2007, 1'b0, 16'h80F1, 8'h3C);
        port_xfer(16'h200A, 1'b1, 8'h10, 8'h3C, -1);
        bad_op   (16'h200C);
        port_xfer(16'h200D, 1'b0, 8'h01, 8'h5B, 5);
        chk("R10", "err cleared by start", 16'(tr[0].err), 16'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog R8: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule